// File: doc/BRIEF.md
# Delayed Transaction Retry Tracker

This block sits in a slow bus target or bridge and lets it accept one request as a delayed transaction. The first time a request arrives, the tracker stores the whole request and answers with a retry, which tells the initiator to stop without moving data. It then issues the stored request on its back-end port and keeps the result once the back end acknowledges. When the initiator repeats exactly the same request, the stored result goes back as a normal, non-retry response and the entry is freed.

While the entry is in use, every other request is answered with retry. A matching repeat that arrives before the back end has finished also gets retry, and the entry stays. Once the result is ready, the tracker waits 2^TMO_LOG2 clocks (32768 by default) for the matching repeat. If none comes, it drops the entry and raises a one-cycle timeout pulse. Reset also clears the entry.

Top module: `dt_retry_tracker`

## Requirements
- R1: After reset, rsp_valid, be_req_valid and tmo_pulse are all 0.
- R2: A request that arrives while no entry is held gets a retry response (rsp_retry=1). On the same clock edge be_req_valid rises, and be_cmd, be_addr, be_be and be_wdata carry the captured fields.
- R3: be_req_valid and the back-end fields stay unchanged until be_ack is sampled high. be_req_valid falls on that edge.
- R4: A matching request that arrives before the back end has acknowledged gets retry. The entry is kept and is delivered later.
- R5: A request that does not match the held entry gets retry. It does not change the back-end request, and it does not change the result that the entry later delivers.
- R6: A match needs equal command, address and byte enables. Write data must also be equal, but only when the command is a write. A write is a command with bit 0 set to 1.
- R7: A matching request that arrives after completion gets rsp_retry=0 and the stored result, and the entry is freed. The next request is captured as a new entry.
- R8: For a read, the result data is be_rdata when be_abort=0 and 32'hFFFF_FFFF when be_abort=1. For a write, the result data is 0. In both cases rsp_err equals be_abort.
- R9: If no matching request arrives, the entry is dropped exactly 2^TMO_LOG2 clocks after the completion edge. tmo_pulse is high for exactly one cycle at that point, and a later identical request is captured afresh.
- R10: rsp_valid is high in exactly the cycle after each cycle in which req_valid is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also acts as bus reset |
| req_valid | input | 1 | Upstream request present this cycle |
| req_cmd | input | CMD_W | Request command; bit 0 set means write |
| req_addr | input | ADDR_W | Request address |
| req_be | input | DATA_W/8 | Request byte enables |
| req_wdata | input | DATA_W | Request write data |
| rsp_valid | output | 1 | Response to the request of the previous cycle |
| rsp_retry | output | 1 | Response is a retry (stop, no data) |
| rsp_data | output | DATA_W | Delivered result data |
| rsp_err | output | 1 | Delivered result carries a back-end abort |
| be_req_valid | output | 1 | Back-end request outstanding |
| be_cmd | output | CMD_W | Back-end command |
| be_addr | output | ADDR_W | Back-end address |
| be_be | output | DATA_W/8 | Back-end byte enables |
| be_wdata | output | DATA_W | Back-end write data |
| be_ack | input | 1 | Back end has completed the request |
| be_rdata | input | DATA_W | Back-end read data, valid with be_ack |
| be_abort | input | 1 | Back end ended with master-abort, valid with be_ack |
| tmo_pulse | output | 1 | One-cycle pulse when an entry is dropped by timeout |

## Verification
The bench repeats a request before the back end acknowledges. A design that hands back data too early would deliver stale or zero data instead of a retry. It sends requests that differ only in address, in byte enables, or in write data. The write-data difference must break a write match but not a read match. A design that compares too little would give one initiator's result to another, and one that compares too much would make reads retry forever. Aborted reads must return all ones and aborted writes zero data, both flagged. The timeout case counts the clocks from completion to the pulse. An off-by-one counter, or one that never restarts, would show up as a wrong count or as a result still delivered after expiry.

// File: rtl/dt_retry_pkg.sv
package dt_retry_pkg;
   typedef enum logic [1:0] {
      ENT_FREE = 2'd0,
      ENT_BUSY = 2'd1,
      ENT_DONE = 2'd2
   } ent_state_t;

   localparam int WRITE_BIT = 0;
endpackage

// File: rtl/dt_req_match.sv
module dt_req_match #(
   parameter int CMD_W       = 4,
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int MATCH_WDATA = 1
) (
   input  logic [CMD_W-1:0]    held_cmd,
   input  logic [ADDR_W-1:0]   held_addr,
   input  logic [DATA_W/8-1:0] held_be,
   input  logic [DATA_W-1:0]   held_wdata,
   input  logic [CMD_W-1:0]    new_cmd,
   input  logic [ADDR_W-1:0]   new_addr,
   input  logic [DATA_W/8-1:0] new_be,
   input  logic [DATA_W-1:0]   new_wdata,
   output logic                same
);
   logic head_eq;
   logic data_eq;

   assign head_eq = (held_cmd == new_cmd) && (held_addr == new_addr) && (held_be == new_be);

   generate
      if (MATCH_WDATA != 0) begin : g_cmp_data
         assign data_eq = !held_cmd[dt_retry_pkg::WRITE_BIT] || (held_wdata == new_wdata);
      end else begin : g_skip_data
         logic unused_data;
         assign unused_data = ^{held_wdata, new_wdata};
         assign data_eq = 1'b1;
      end
   endgenerate

   assign same = head_eq && data_eq;
endmodule

// File: rtl/dt_expiry_timer.sv
module dt_expiry_timer #(
   parameter int TMO_LOG2 = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic expire
);
   logic [TMO_LOG2-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expire = run && (cnt_q == {TMO_LOG2{1'b1}});
endmodule

// File: rtl/dt_retry_tracker.sv
module dt_retry_tracker #(
   parameter int CMD_W       = 4,
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int TMO_LOG2    = 15,
   parameter int MATCH_WDATA = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [CMD_W-1:0]    req_cmd,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W/8-1:0] req_be,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                rsp_valid,
   output logic                rsp_retry,
   output logic [DATA_W-1:0]   rsp_data,
   output logic                rsp_err,
   output logic                be_req_valid,
   output logic [CMD_W-1:0]    be_cmd,
   output logic [ADDR_W-1:0]   be_addr,
   output logic [DATA_W/8-1:0] be_be,
   output logic [DATA_W-1:0]   be_wdata,
   input  logic                be_ack,
   input  logic [DATA_W-1:0]   be_rdata,
   input  logic                be_abort,
   output logic                tmo_pulse
);
   import dt_retry_pkg::*;

   localparam int BE_W = DATA_W / 8;

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data_w
      $error("dt_retry_tracker: DATA_W must be a positive multiple of 8");
   end
   if (TMO_LOG2 < 1 || TMO_LOG2 > 30) begin : g_bad_tmo
      $error("dt_retry_tracker: TMO_LOG2 out of range");
   end
   if (CMD_W < 1) begin : g_bad_cmd
      $error("dt_retry_tracker: CMD_W must be at least 1");
   end

   ent_state_t          st_q;
   logic [CMD_W-1:0]    h_cmd_q;
   logic [ADDR_W-1:0]   h_addr_q;
   logic [BE_W-1:0]     h_be_q;
   logic [DATA_W-1:0]   h_wdata_q;
   logic [DATA_W-1:0]   res_data_q;
   logic                res_err_q;

   logic same;
   logic hit;
   logic capture;
   logic complete;
   logic deliver;
   logic expire;
   logic drop;

   dt_req_match #(
      .CMD_W       (CMD_W),
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .MATCH_WDATA (MATCH_WDATA)
   ) u_match (
      .held_cmd   (h_cmd_q),
      .held_addr  (h_addr_q),
      .held_be    (h_be_q),
      .held_wdata (h_wdata_q),
      .new_cmd    (req_cmd),
      .new_addr   (req_addr),
      .new_be     (req_be),
      .new_wdata  (req_wdata),
      .same       (same)
   );

   assign capture  = req_valid && (st_q == ENT_FREE);
   assign hit      = req_valid && (st_q != ENT_FREE) && same;
   assign complete = (st_q == ENT_BUSY) && be_ack;
   assign deliver  = hit && (st_q == ENT_DONE);
   assign drop     = expire && !deliver;

   dt_expiry_timer #(
      .TMO_LOG2 (TMO_LOG2)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (complete || capture),
      .run     (st_q == ENT_DONE),
      .expire  (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ENT_FREE;
      end else begin
         unique case (st_q)
            ENT_FREE: if (capture)          st_q <= ENT_BUSY;
            ENT_BUSY: if (complete)         st_q <= ENT_DONE;
            ENT_DONE: if (deliver || drop)  st_q <= ENT_FREE;
            default:                        st_q <= ENT_FREE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_cmd_q   <= '0;
         h_addr_q  <= '0;
         h_be_q    <= '0;
         h_wdata_q <= '0;
      end else if (capture) begin
         h_cmd_q   <= req_cmd;
         h_addr_q  <= req_addr;
         h_be_q    <= req_be;
         h_wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_data_q <= '0;
         res_err_q  <= 1'b0;
      end else if (complete) begin
         res_err_q <= be_abort;
         if (h_cmd_q[WRITE_BIT]) begin
            res_data_q <= '0;
         end else if (be_abort) begin
            res_data_q <= '1;
         end else begin
            res_data_q <= be_rdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_retry <= 1'b0;
         rsp_data  <= '0;
         rsp_err   <= 1'b0;
         tmo_pulse <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_retry <= req_valid && !deliver;
         rsp_data  <= deliver ? res_data_q : '0;
         rsp_err   <= deliver ? res_err_q : 1'b0;
         tmo_pulse <= drop;
      end
   end

   assign be_req_valid = (st_q == ENT_BUSY);
   assign be_cmd       = h_cmd_q;
   assign be_addr      = h_addr_q;
   assign be_be        = h_be_q;
   assign be_wdata     = h_wdata_q;
endmodule

// File: rtl/dt_retry_tracker_chk.sv
module dt_retry_tracker_chk #(
   parameter int CMD_W  = 4,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                rsp_valid,
   input logic                rsp_retry,
   input logic                rsp_err,
   input logic [DATA_W-1:0]   rsp_data,
   input logic                be_req_valid,
   input logic [CMD_W-1:0]    be_cmd,
   input logic [ADDR_W-1:0]   be_addr,
   input logic                be_ack,
   input logic                tmo_pulse
);
   // R3: the back-end request holds steady until acknowledged
   a_r3_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      be_req_valid && !be_ack |=> be_req_valid && $stable(be_addr) && $stable(be_cmd));

   // R3: acknowledge ends the back-end request
   a_r3_ack_ends: assert property (@(posedge clk) disable iff (!rst_n)
      be_req_valid && be_ack |=> !be_req_valid);

   // R10: one response per request, one cycle later
   a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R2: a new back-end request comes only from a request answered with retry
   a_r2_capture_retry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(be_req_valid) |-> rsp_valid && rsp_retry);

   // R4: no data is delivered while the back end is still busy
   a_r4_no_early_data: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_retry |-> !be_req_valid);

   // R9: the timeout pulse lasts one cycle
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_pulse |=> !tmo_pulse);

   // R8: a retry carries no data and no error
   a_r8_retry_clean: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_retry |-> rsp_data == '0 && !rsp_err);
endmodule

bind dt_retry_tracker dt_retry_tracker_chk #(
   .CMD_W  (CMD_W),
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .rsp_valid    (rsp_valid),
   .rsp_retry    (rsp_retry),
   .rsp_err      (rsp_err),
   .rsp_data     (rsp_data),
   .be_req_valid (be_req_valid),
   .be_cmd       (be_cmd),
   .be_addr      (be_addr),
   .be_ack       (be_ack),
   .tmo_pulse    (tmo_pulse)
);

// File: tb/dt_retry_tracker_test.sv
module dt_retry_tracker_test;
   localparam int TMO_LOG2 = 15;
   localparam int LIMIT    = 1 << TMO_LOG2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [3:0]  req_cmd = '0;
   logic [31:0] req_addr = '0;
   logic [3:0]  req_be = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, rsp_retry, rsp_err;
   logic [31:0] rsp_data;
   logic        be_req_valid;
   logic [3:0]  be_cmd;
   logic [31:0] be_addr;
   logic [3:0]  be_be;
   logic [31:0] be_wdata;
   logic        be_ack = 1'b0;
   logic [31:0] be_rdata = '0;
   logic        be_abort = 1'b0;
   logic        tmo_pulse;

   int checks = 0;
   int fails = 0;

   always #2 clk = ~clk;

   dt_retry_tracker #(.TMO_LOG2(TMO_LOG2)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
      .req_be(req_be), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_retry(rsp_retry), .rsp_data(rsp_data), .rsp_err(rsp_err),
      .be_req_valid(be_req_valid), .be_cmd(be_cmd), .be_addr(be_addr),
      .be_be(be_be), .be_wdata(be_wdata),
      .be_ack(be_ack), .be_rdata(be_rdata), .be_abort(be_abort),
      .tmo_pulse(tmo_pulse)
   );

   // {cmd[104:101], addr[100:69], be[68:65], wdata[64:33], rdata[32:1], abort[0]}
   localparam logic [104:0] VEC [6] = '{
      {4'h6, 32'h0000_1000, 4'hF, 32'h0000_0000, 32'hCAFE_0001, 1'b0},
      {4'h7, 32'h0000_2004, 4'h3, 32'h1234_5678, 32'h0000_0000, 1'b0},
      {4'h6, 32'h8000_0010, 4'h1, 32'h0000_0000, 32'h5555_AAAA, 1'b1},
      {4'h2, 32'h0000_0CF8, 4'h0, 32'h0000_0000, 32'h0000_00A5, 1'b0},
      {4'h3, 32'h0000_0080, 4'hC, 32'hDEAD_BEEF, 32'h0000_0001, 1'b1},
      {4'hA, 32'hFFFF_FFFC, 4'hF, 32'h0000_0000, 32'h7F7F_7F7F, 1'b0}
   };

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [3:0] c, input logic [31:0] a, input logic [3:0] b, input logic [31:0] w);
      req_valid = 1'b1; req_cmd = c; req_addr = a; req_be = b; req_wdata = w;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic ack(input logic [31:0] d, input logic ab);
      be_ack = 1'b1; be_rdata = d; be_abort = ab;
      @(negedge clk);
      be_ack = 1'b0; be_abort = 1'b0;
   endtask

   task automatic expect_retry(input string tag);
      check(rsp_valid && rsp_retry, tag, {30'd0, rsp_valid, rsp_retry}, 32'h3);
   endtask

   task automatic expect_data(input string tag, input logic [31:0] d, input logic e);
      check(rsp_valid && !rsp_retry && rsp_data == d && rsp_err == e, tag, rsp_data, d);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      check(!rsp_valid && !be_req_valid && !tmo_pulse, "R1 reset state",
            {29'd0, rsp_valid, be_req_valid, tmo_pulse}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 6; i++) begin
         logic [3:0]  c;
         logic [31:0] a, w, d, expd;
         logic [3:0]  b;
         logic        ab;
         c = VEC[i][104:101]; a = VEC[i][100:69]; b = VEC[i][68:65];
         w = VEC[i][64:33]; d = VEC[i][32:1]; ab = VEC[i][0];
         expd = c[0] ? 32'd0 : (ab ? 32'hFFFF_FFFF : d);

         send(c, a, b, w);
         expect_retry("R2 first attempt retried");
         check(be_req_valid && be_cmd == c && be_addr == a && be_be == b && be_wdata == w,
               "R2 back-end fields", be_addr, a);
         @(negedge clk);
         check(rsp_valid == 1'b0, "R10 single response cycle", {31'd0, rsp_valid}, 32'd0);
         send(c, a ^ 32'h4, b, w);
         expect_retry("R5 other request retried");
         check(be_req_valid && be_addr == a, "R5 back-end untouched", be_addr, a);
         send(c, a, b, w);
         expect_retry("R4 early repeat retried");
         repeat (3) @(negedge clk);
         check(be_req_valid && be_addr == a, "R3 request held before ack", be_addr, a);
         ack(d, ab);
         check(!be_req_valid, "R3 request dropped on ack", {31'd0, be_req_valid}, 32'd0);
         send(c, a, b, w);
         expect_data("R7 R8 delivered result", expd, ab);
         send(c, a, b, w);
         expect_retry("R7 entry freed, recaptured");
         check(be_req_valid, "R7 new back-end request", {31'd0, be_req_valid}, 32'd1);
         ack(d, ab);
         send(c, a, b, w);
         expect_data("R7 second delivery", expd, ab);
      end

      // R6: read ignores write-data difference
      send(4'h6, 32'h0000_3000, 4'hF, 32'h1111_1111);
      ack(32'hA1B2_C3D4, 1'b0);
      send(4'h6, 32'h0000_3000, 4'hF, 32'h2222_2222);
      expect_data("R6 read matches despite wdata", 32'hA1B2_C3D4, 1'b0);

      // R6: write data and byte enables must match
      send(4'h7, 32'h0000_4000, 4'hF, 32'hAAAA_0000);
      ack(32'h0, 1'b0);
      send(4'h7, 32'h0000_4000, 4'hF, 32'hAAAA_0001);
      expect_retry("R6 write wdata mismatch retried");
      send(4'h7, 32'h0000_4000, 4'h7, 32'hAAAA_0000);
      expect_retry("R6 byte enable mismatch retried");
      send(4'h6, 32'h0000_4000, 4'hF, 32'hAAAA_0000);
      expect_retry("R6 command mismatch retried");
      send(4'h7, 32'h0000_4000, 4'hF, 32'hAAAA_0000);
      expect_data("R6 R5 exact write delivered", 32'h0, 1'b0);

      // R9: timeout exactly LIMIT clocks after completion
      send(4'h6, 32'h0000_5000, 4'hF, 32'h0);
      ack(32'h0BAD_F00D, 1'b0);
      begin
         int n = 0;
         while (!tmo_pulse && n < LIMIT + 10) begin
            @(negedge clk);
            n++;
         end
         check(n == LIMIT, "R9 timeout distance", n, LIMIT);
      end
      @(negedge clk);
      check(!tmo_pulse, "R9 pulse one cycle", {31'd0, tmo_pulse}, 32'd0);
      send(4'h6, 32'h0000_5000, 4'hF, 32'h0);
      expect_retry("R9 dropped entry recaptured");
      check(be_req_valid, "R9 new back-end request", {31'd0, be_req_valid}, 32'd1);
      ack(32'h0000_0042, 1'b0);
      send(4'h6, 32'h0000_5000, 4'hF, 32'h0);
      expect_data("R9 fresh result delivered", 32'h0000_0042, 1'b0);

      // R1: reset clears a pending entry
      send(4'h6, 32'h0000_6000, 4'hF, 32'h0);
      rst_n = 1'b0;
      @(negedge clk);
      check(!be_req_valid && !rsp_valid, "R1 reset clears entry",
            {30'd0, be_req_valid, rsp_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule